// File: doc/BRIEF.md
# Sub-Word Load Data Aligner

This block sits on the write-back path between a word-aligned data memory and the register file. The memory always returns the whole 32-bit word that contains the addressed byte, fetched at the address rounded down to a multiple of four. The aligner takes that word, the load instruction and the full effective address, whose low two bits are still present. It picks out the byte, halfword or word the instruction asks for and sign-extends it to register width.

The load width is decoded from the instruction word itself. No separate control line carries it. The byte lane comes from address bits [1:0]. Any combination the block does not support produces zero: an access that would cross the fetched word, an unknown width code, or an instruction that is not a load. The result is captured in an output register, so it appears one clock after the inputs are presented. A synchronous active-high reset clears that register.

Top module: `lda_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o` becomes zero at that edge, whatever the data inputs hold.
- R2: For a byte load (opcode bits [6:0] = 0000011, funct3 bits [14:12] = 000), address offset k (addr bits [1:0] = 0, 1, 2, 3) selects fetched bits [8k+7:8k], and that byte is sign-extended to 32 bits.
- R3: For a halfword load (opcode 0000011, funct3 = 001), offsets 0, 1 and 2 select fetched bits [15:0], [23:8] and [31:16], and that halfword is sign-extended to 32 bits.
- R4: A word load (opcode 0000011, funct3 = 010) at offset 0 returns the fetched word unchanged.
- R5: The result is zero for a halfword at offset 3, a word at offset 1, 2 or 3, and any funct3 other than 000, 001 and 010.
- R6: The result is zero when opcode bits [6:0] differ from 0000011, whatever funct3 and the address hold.
- R7: Address bits [31:2] and instruction bits [31:15] and [11:7] have no effect on the result.
- R8: The result for inputs sampled at a rising edge appears at `result_o` right after that edge and holds until the next edge. Back-to-back loads each get their own result, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Load instruction being executed |
| addr_i | input | 32 | Effective address, low two bits intact |
| rdata_i | input | 32 | Word read from memory at the aligned address |
| result_o | output | 32 | Value to write to the destination register |

## Verification
The block holds no state except its output register, so any wrong decode or lane choice shows at `result_o` in the cycle after the offending inputs. A wrong lane gives the wrong byte. A missed sign extension shows in the upper bits. A wrongly accepted unsupported case gives a nonzero value where zero is required. Random data words with both sign-bit values are used for each case, so that swapped lanes and wrong extension widths do not hide behind equal bytes. Each result is compared one cycle after its inputs, which also exposes an extra or missing pipeline stage.

// File: rtl/lda_pkg.sv
package lda_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [6:0] LOAD_OPCODE = 7'b0000011;
  localparam logic [2:0] F3_BYTE = 3'b000;
  localparam logic [2:0] F3_HALF = 3'b001;
  localparam logic [2:0] F3_WORD = 3'b010;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_BYTE = 2'd1,
    LD_HALF = 2'd2,
    LD_WORD = 2'd3
  } ld_width_e;
endpackage

// File: rtl/lda_decode.sv
module lda_decode
  import lda_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output ld_width_e       width
);
  logic [6:0] opcode;
  logic [2:0] funct3;

  assign opcode = instr[6:0];
  assign funct3 = instr[14:12];

  always_comb begin
    width = LD_NONE;
    if (opcode == LOAD_OPCODE) begin
      unique case (funct3)
        F3_BYTE: width = LD_BYTE;
        F3_HALF: width = LD_HALF;
        F3_WORD: width = LD_WORD;
        default: width = LD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lda_lane_sel.sv
module lda_lane_sel
  import lda_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  ld_width_e                         width,
  input  logic [$clog2(XLEN/BYTE_W)-1:0]    offset,
  input  logic [XLEN-1:0]                   word,
  output logic [XLEN-1:0]                   value
);
  localparam int unsigned LANES = XLEN / BYTE_W;
  localparam int unsigned OFF_W = $clog2(LANES);
  localparam int unsigned HALF_W = 2 * BYTE_W;
  localparam logic [OFF_W-1:0] LAST_HALF_OFF = OFF_W'(LANES - 2);

  logic [LANES-1:0][XLEN-1:0] byte_ext;
  logic [LANES-1:0][XLEN-1:0] half_ext;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] b;
    assign b = word[g*BYTE_W +: BYTE_W];
    assign byte_ext[g] = {{(XLEN-BYTE_W){b[BYTE_W-1]}}, b};
    if (g < LANES - 1) begin : g_half
      logic [HALF_W-1:0] h;
      assign h = word[g*BYTE_W +: HALF_W];
      assign half_ext[g] = {{(XLEN-HALF_W){h[HALF_W-1]}}, h};
    end else begin : g_nohalf
      assign half_ext[g] = '0;
    end
  end

  always_comb begin
    value = '0;
    unique case (width)
      LD_BYTE: value = byte_ext[offset];
      LD_HALF: if (offset <= LAST_HALF_OFF) value = half_ext[offset];
      LD_WORD: if (offset == '0) value = word;
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/lda_aligner.sv
module lda_aligner
  import lda_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] result_o
);
  localparam int unsigned OFF_W = $clog2(XLEN / BYTE_W);

  ld_width_e       width;
  logic [XLEN-1:0] aligned_val;

  lda_decode #(.XLEN(XLEN)) u_decode (
    .instr (instr_i),
    .width (width)
  );

  lda_lane_sel #(.XLEN(XLEN)) u_lane (
    .width  (width),
    .offset (addr_i[OFF_W-1:0]),
    .word   (rdata_i),
    .value  (aligned_val)
  );

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= aligned_val;
  end
endmodule

// File: rtl/lda_aligner_chk.sv
module lda_aligner_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] addr_i,
  input logic [XLEN-1:0] rdata_i,
  input logic [XLEN-1:0] result_o
);
  logic is_load, is_b, is_h, is_w, bad_combo;
  assign is_load   = instr_i[6:0] == 7'b0000011;
  assign is_b      = is_load && instr_i[14:12] == 3'b000;
  assign is_h      = is_load && instr_i[14:12] == 3'b001 && addr_i[1:0] != 2'b11;
  assign is_w      = is_load && instr_i[14:12] == 3'b010 && addr_i[1:0] == 2'b00;
  assign bad_combo = !(is_b || is_h || is_w);

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> result_o == '0);

  // R2
  byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(is_b) |-> result_o[XLEN-1:8] == {(XLEN-8){result_o[7]}});

  // R3
  half_sext_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(is_h) |-> result_o[XLEN-1:16] == {(XLEN-16){result_o[15]}});

  // R4
  word_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(is_w) |-> result_o == $past(rdata_i));

  // R5
  unsupported_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(bad_combo) |-> result_o == '0);
endmodule

bind lda_aligner lda_aligner_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .instr_i  (instr_i),
  .addr_i   (addr_i),
  .rdata_i  (rdata_i),
  .result_o (result_o)
);

// File: tb/lda_aligner_test.sv
`timescale 1ns/1ps
module lda_aligner_test;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [31:0] addr_i = '0;
  logic [31:0] rdata_i = '0;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;
  item_t sb_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  lda_aligner uut (
    .clk(clk), .rst(rst), .instr_i(instr_i),
    .addr_i(addr_i), .rdata_i(rdata_i), .result_o(result_o)
  );

  function automatic logic [31:0] model(input logic [6:0] op, input logic [2:0] f3,
                                        input logic [1:0] off, input logic [31:0] d);
    logic [7:0]  b;
    logic [15:0] h;
    if (op != 7'b0000011) return 32'h0;
    case (f3)
      3'b000: begin
        case (off)
          2'd0: b = d[7:0];
          2'd1: b = d[15:8];
          2'd2: b = d[23:16];
          default: b = d[31:24];
        endcase
        return {{24{b[7]}}, b};
      end
      3'b001: begin
        case (off)
          2'd0: h = d[15:0];
          2'd1: h = d[23:8];
          2'd2: h = d[31:16];
          default: return 32'h0;
        endcase
        return {{16{h[15]}}, h};
      end
      3'b010: return (off == 2'd0) ? d : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive(input logic [6:0] op, input logic [2:0] f3, input logic [1:0] off,
                       input logic [31:0] d, input string tag);
    item_t it;
    @(negedge clk);
    instr_i = {$urandom()} [31:0];
    instr_i[6:0] = op;
    instr_i[14:12] = f3;
    addr_i = {$urandom()} [31:0];
    addr_i[1:0] = off;
    rdata_i = d;
    it.exp = model(op, f3, off, d);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (result_o !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.tag, result_o, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    localparam logic [6:0] LD = 7'b0000011;
    // R1: reset with a valid word load presented must give zero
    @(negedge clk);
    rst = 1'b1; instr_i = 32'h0000_2003; addr_i = 32'h0; rdata_i = 32'hDEAD_BEEF;
    @(posedge clk); #2;
    total++;
    if (result_o !== 32'h0) begin
      bad++;
      $display("FAIL R1: got %h expected %h", result_o, 32'h0);
    end
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;

    for (int n = 0; n < 8; n++) begin
      logic [31:0] d;
      d = $urandom();
      if (n == 0) d = 32'h80FF_7F01;
      if (n == 1) d = 32'h7F80_017F;
      // R2: byte lanes 0..3
      for (int k = 0; k < 4; k++) drive(LD, 3'b000, 2'(k), d, "R2 byte lane");
      // R3: halfword offsets 0..2
      for (int k = 0; k < 3; k++) drive(LD, 3'b001, 2'(k), d, "R3 halfword lane");
      // R4: word at offset 0
      drive(LD, 3'b010, 2'd0, d, "R4 word passthrough");
      // R5: unsupported combinations
      drive(LD, 3'b001, 2'd3, d, "R5 halfword offset 3");
      for (int k = 1; k < 4; k++) drive(LD, 3'b010, 2'(k), d, "R5 word misaligned");
      for (int f = 3; f < 8; f++) drive(LD, 3'(f), 2'(n), d, "R5 unknown funct3");
      // R6: non-load opcodes
      drive(7'b0100011, 3'b010, 2'd0, d, "R6 store opcode");
      drive(7'b0010011, 3'b000, 2'(n), d, "R6 alu opcode");
    end
    // R7: same low bits with differing upper address/instr bits
    for (int n = 0; n < 16; n++) drive(LD, 3'(n % 3), 2'd0, 32'hA5C3_9681, "R7 upper bits ignored");
    // R8: back-to-back alternating loads checked one per cycle
    for (int n = 0; n < 24; n++) drive(LD, 3'(n % 2), 2'(n % 3), $urandom(), "R8 back to back");

    @(negedge clk);
    instr_i = '0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule